// File: doc/BRIEF.md
# Framed DDR Serial-to-Parallel Deserializer

This block turns up to four serial lanes into parallel sample words. Every lane carries one bit on each edge of a shared data clock. A separate frame signal, sampled in the same clock domain, marks where each 14-bit word begins. A negative-edge register holds the bit sent during the low phase. On the next rising edge, that held bit and the bit present at the rising edge are shifted into the lane's word register together. All word logic therefore runs on the rising edge only and counts 7 pairs per word, not 14 bits.

At each frame boundary that closes a complete word, every lane's word is copied to its parallel output with the top bit inverted. This turns offset-binary samples into two's complement. A one-cycle strobe flags the new word. The block stays idle until it has seen its first frame boundary. The pair count restarts at every boundary, so a slipped frame costs at most one word and never leaves a lasting misalignment.

Top module: `ddr_frame_deser`

## Requirements
- R1: While `rst_ni` is low, `dout_o` is all zeros and `valid_o` is 0.
- R2: Within a pair, the bit sampled at the falling edge comes before the bit sampled at the following rising edge. The first bit of a word lands in bit 13 and the last bit in bit 0.
- R3: `frame_i` is sampled on rising edges of `clk_i`. A boundary is a rising edge where `frame_i` is 1 and was 0 at the previous rising edge. The pair completed at that edge is the first pair of the new word.
- R4: Nothing is latched and `valid_o` stays 0 until one boundary has been seen after reset. The first boundary itself emits no word.
- R5: At a boundary reached after exactly 7 pairs since the previous boundary, each lane's output becomes the 7 pairs it assembled, with bit 13 inverted. The new value is visible right after that rising edge.
- R6: `valid_o` is 1 for exactly the one clock cycle that follows each latch, and 0 otherwise.
- R7: A boundary reached after any pair count other than 7 latches nothing, and the outputs keep their value. The count restarts at that boundary, so the next complete word is emitted normally.
- R8: Lane n is taken from `din_i[n]` and appears on `dout_o[n*14 +: 14]`. Lanes do not affect each other.
- R9: Between latches, `dout_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Data clock; data is valid at both of its edges |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | Frame marker; a rise marks the first pair of a word |
| din_i | input | LANES | One serial data bit per lane |
| dout_o | output | LANES*WORD_W | Parallel words in two's complement, lane 0 in the low bits |
| valid_o | output | 1 | One-cycle strobe that flags a new word |

## Verification
The assertions assume that `frame_i` changes only between rising edges and stays low for at least one rising edge between boundaries. They also assume that serial data is stable around both clock edges. The stimulus meets these conditions by design. It changes the data just after each edge, raises the frame signal for one pair only, and drops it before the next pair. The misalignment scenarios add or remove whole pairs but never change the frame pulse's shape, so the checker's pair count since the last boundary is always well defined.

// File: rtl/ddr_deser_pkg.sv
package ddr_deser_pkg;
  parameter int unsigned DEF_LANES  = 4;
  parameter int unsigned DEF_WORD_W = 14;

  // bits per rising edge: one from the low phase, one at the edge
  localparam int unsigned BITS_PER_EDGE = 2;
endpackage

// File: rtl/ddr_frame_ctrl.sv
module ddr_frame_ctrl #(
  parameter int unsigned PAIRS = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_i,
  output logic shift_en_o,
  output logic load_o,
  output logic valid_o
);
  localparam int unsigned CNT_W = $clog2(PAIRS + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(PAIRS);

  logic             frame_q;
  logic             armed_q;
  logic [CNT_W-1:0] cnt_q;
  logic             frame_rise;

  assign frame_rise = frame_i & ~frame_q;
  assign load_o     = frame_rise & armed_q & (cnt_q == CNT_FULL);
  assign shift_en_o = armed_q | frame_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= 1'b0;
      armed_q <= 1'b0;
      cnt_q   <= '0;
      valid_o <= 1'b0;
    end else begin
      frame_q <= frame_i;
      valid_o <= load_o;
      if (frame_rise) begin
        armed_q <= 1'b1;
        cnt_q   <= CNT_W'(1);
      end else if (armed_q && cnt_q <= CNT_FULL) begin
        // saturates one past full so an overlong word is never accepted
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/ddr_lane_sipo.sv
module ddr_lane_sipo #(
  parameter int unsigned WORD_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              din_i,
  input  logic              shift_en_i,
  input  logic              load_i,
  output logic [WORD_W-1:0] word_o
);
  logic              fall_q;
  logic [WORD_W-1:0] sh_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fall_q <= 1'b0;
    else         fall_q <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      word_o <= '0;
    end else begin
      if (shift_en_i) sh_q <= {sh_q[WORD_W-3:0], fall_q, din_i};
      // MSB flip: offset binary to two's complement
      if (load_i) word_o <= {~sh_q[WORD_W-1], sh_q[WORD_W-2:0]};
    end
  end
endmodule

// File: rtl/ddr_frame_deser.sv
module ddr_frame_deser
  import ddr_deser_pkg::*;
#(
  parameter int unsigned LANES  = DEF_LANES,
  parameter int unsigned WORD_W = DEF_WORD_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    frame_i,
  input  logic [LANES-1:0]        din_i,
  output logic [LANES*WORD_W-1:0] dout_o,
  output logic                    valid_o
);
  localparam int unsigned PAIRS = WORD_W / BITS_PER_EDGE;

  logic shift_en;
  logic load;

  ddr_frame_ctrl #(.PAIRS(PAIRS)) i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .frame_i    (frame_i),
    .shift_en_o (shift_en),
    .load_o     (load),
    .valid_o    (valid_o)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    ddr_lane_sipo #(.WORD_W(WORD_W)) i_lane (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .din_i      (din_i[g]),
      .shift_en_i (shift_en),
      .load_i     (load),
      .word_o     (dout_o[g*WORD_W +: WORD_W])
    );
  end
endmodule

// File: rtl/ddr_frame_deser_chk.sv
module ddr_frame_deser_chk #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned WORD_W = 14
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    frame_i,
  input logic [LANES-1:0]        din_i,
  input logic [LANES*WORD_W-1:0] dout_o,
  input logic                    valid_o
);
  localparam int unsigned PAIRS = WORD_W / 2;
  localparam int unsigned GAP_W = $clog2(PAIRS + 2);

  logic             fr_q;
  logic             seen_q;
  logic [GAP_W-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fr_q   <= 1'b0;
      seen_q <= 1'b0;
      gap_q  <= '0;
    end else begin
      fr_q <= frame_i;
      if (frame_i && !fr_q) begin
        seen_q <= 1'b1;
        gap_q  <= GAP_W'(1);
      end else if (seen_q && gap_q <= GAP_W'(PAIRS)) begin
        gap_q <= gap_q + GAP_W'(1);
      end
    end
  end

  always_comb begin
    if (!rst_ni) begin
      assert_reset_clear_R1: assert (valid_o == 1'b0);
    end
  end

  assert_valid_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  assert_hold_between_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(dout_o));

  assert_load_on_frame_rise_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ($past(frame_i) && !$past(frame_i, 2)));

  assert_armed_first_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(seen_q));

  assert_full_word_only_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ($past(gap_q) == GAP_W'(PAIRS)));
endmodule

bind ddr_frame_deser ddr_frame_deser_chk #(.LANES(LANES), .WORD_W(WORD_W)) i_chk (.*);

// File: tb/test_ddr_frame_deser.sv
module test_ddr_frame_deser;
  localparam int L = 4;
  localparam int W = 14;
  localparam int P = W / 2;
  localparam time CLK_PERIOD = 10;

  logic           clk_i = 1'b0;
  logic           rst_ni;
  logic           frame_i;
  logic [L-1:0]   din_i;
  logic [L*W-1:0] dout_o;
  logic           valid_o;

  int total = 0;
  int bad   = 0;
  logic [L*W-1:0] last_out;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ddr_frame_deser #(.LANES(L), .WORD_W(W)) i_ddr_frame_deser (.*);

  function automatic logic [L*W-1:0] conv(input logic [L*W-1:0] w);
    logic [L*W-1:0] r = w;
    for (int n = 0; n < L; n++) r[n*W + W-1] = ~w[n*W + W-1];
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [L*W-1:0] act,
                       input logic [L*W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // entered just after a rising edge; returns just after the edge that takes the pair
  task automatic drive_pair(input logic [L-1:0] f, input logic [L-1:0] r, input logic fr);
    din_i = f;
    @(negedge clk_i); #1;
    din_i   = r;
    frame_i = fr;
    @(posedge clk_i); #1;
  endtask

  // first serial bit = word bit 13 (R2); lane n in bits n*W (R8)
  task automatic send_word(input logic [L*W-1:0] w, input int npairs, input bit mark,
                           input bit exp_v, input logic [L*W-1:0] exp_d, input string tag);
    for (int p = 0; p < npairs; p++) begin
      logic [L-1:0] f, r;
      for (int n = 0; n < L; n++) begin
        f[n] = (p < P) ? w[n*W + W-1 - 2*p] : 1'b0;
        r[n] = (p < P) ? w[n*W + W-2 - 2*p] : 1'b0;
      end
      drive_pair(f, r, mark && p == 0);
      if (p == 0) begin
        check(valid_o == exp_v, {tag, " R6 valid at boundary"}, {55'b0, valid_o}, {55'b0, exp_v});
        check(dout_o == exp_d, {tag, " R5 R7 word at boundary"}, dout_o, exp_d);
        last_out = dout_o;
      end else begin
        check(valid_o == 1'b0, {tag, " R6 valid one cycle"}, {55'b0, valid_o}, '0);
        check(dout_o == last_out, {tag, " R9 hold"}, dout_o, last_out);
      end
    end
  endtask

  task automatic t_reset;
    check(dout_o == '0 && valid_o == 1'b0, "R1 reset state", dout_o, '0);
  endtask

  task automatic t_arming(output logic [L*W-1:0] prev);
    logic [L*W-1:0] a = {14'h0123, 14'h3FFF, 14'h0000, 14'h2AAA};
    logic [L*W-1:0] b = {14'h2000, 14'h1FFF, 14'h1555, 14'h3C3C};
    // pairs before any frame: ignored (R4)
    send_word({L*W{1'b1}}, 3, 1'b0, 1'b0, '0, "R4 preframe");
    send_word(a, P, 1'b1, 1'b0, '0, "R4 first boundary");
    send_word(b, P, 1'b1, 1'b1, conv(a), "R2 R8 first word");
    prev = b;
  endtask

  task automatic t_patterns(inout logic [L*W-1:0] prev);
    logic [L*W-1:0] pats [5];
    pats[0] = {14'h0000, 14'h0001, 14'h2000, 14'h3FFE};
    pats[1] = {14'h3FFF, 14'h1FFF, 14'h0F0F, 14'h0001};
    pats[2] = {14'h1234, 14'h2345, 14'h3456, 14'h0567};
    pats[3] = {14'h2AAA, 14'h1555, 14'h2AAA, 14'h1555};
    pats[4] = {14'h0800, 14'h0400, 14'h0200, 14'h0100};
    for (int i = 0; i < 5; i++) begin
      send_word(pats[i], P, 1'b1, 1'b1, conv(prev), "R5 pattern");
      prev = pats[i];
    end
  endtask

  task automatic t_misalign(inout logic [L*W-1:0] prev);
    logic [L*W-1:0] a = {14'h3001, 14'h0A0A, 14'h1111, 14'h2222};
    logic [L*W-1:0] b = {14'h0F00, 14'h00F0, 14'h000F, 14'h3333};
    logic [L*W-1:0] c = {14'h2468, 14'h1357, 14'h0ACE, 14'h3BDF};
    logic [L*W-1:0] d = {14'h3210, 14'h0123, 14'h2301, 14'h1032};
    logic [L*W-1:0] e = {14'h0777, 14'h3888, 14'h1999, 14'h2666};
    logic [L*W-1:0] f = {14'h1C1C, 14'h2E2E, 14'h0303, 14'h3F00};
    logic [L*W-1:0] held;
    send_word(a, P, 1'b1, 1'b1, conv(prev), "R7 before slip");
    held = conv(prev);
    // frame late by one clock: 8 pairs before next boundary
    send_word('0, 1, 1'b0, 1'b0, held, "R7 extra pair");
    send_word(b, P, 1'b1, 1'b0, held, "R7 long word dropped");
    send_word(c, P, 1'b1, 1'b1, conv(b), "R7 recovered after late");
    // frame early: only 5 pairs
    send_word(d, 5, 1'b1, 1'b1, conv(c), "R7 before short");
    send_word(e, P, 1'b1, 1'b0, conv(c), "R7 short word dropped");
    send_word(f, P, 1'b1, 1'b1, conv(e), "R7 recovered after early");
    send_word('0, 1, 1'b1, 1'b1, conv(f), "R5 final");
    prev = '0;
  endtask

  task automatic finish_up;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [L*W-1:0] prev;
    rst_ni  = 1'b0;
    frame_i = 1'b0;
    din_i   = '0;
    last_out = '0;
    repeat (3) @(posedge clk_i);
    #1;
    t_reset();
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i); #1;
    t_reset();
    t_arming(prev);
    t_patterns(prev);
    t_misalign(prev);
    finish_up();
  end
endmodule